// File: doc/BRIEF.md
# Glitch-Free PWM Generator

This block converts an N-bit level into a pulse train whose high time is proportional to that level. An external RC or LC low-pass network averages the train into a voltage, so the block and the filter together form a simple digital-to-analog converter. A free-running up-counter provides the digital ramp. A registered magnitude compare against a held copy of the level produces the output bit. One PWM period is 2^N counter clocks. With the default N = 8 and a 51.2 MHz clock, the pulse rate is 200 kHz, which leaves a factor of 20 above a 10 kHz signal band.

The level input may change at any moment. The block copies it into its working register only on the clock edge at which the counter returns to zero. A mid-period update therefore cannot shorten a pulse or add a second one. A one-clock strobe marks the first clock of every period, which is also the first clock that uses a newly loaded level. Downstream logic, such as a sample sequencer, can use it to pace its updates.

Top module: `pwm_dac_core`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `pwm_o` and `period_start_o` are low. The working level clears to zero, so the first full period after reset is entirely low.
- R2: `period_start_o` is high on exactly one clock in every 256 (2^WIDTH) consecutive clocks.
- R3: The period begins with the clock on which `period_start_o` is high. Within a period using level D, `pwm_o` is high on clocks 0 through D-1 and low on clocks D through 255.
- R4: Level 0x00 keeps `pwm_o` low for the whole period.
- R5: Level 0xFF gives 255 high clocks followed by one low clock, so the last clock of every period is low.
- R6: A change of `duty_in` after a period has begun does not alter that period's waveform. The new value governs the next period.
- R7: A period uses the value of `duty_in` sampled on the rising clock edge one clock before the edge that raises `period_start_o`. A change made one clock later is deferred by a whole period.
- R8: `period_start_o` is a single-clock pulse; it is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_in | input | WIDTH | Requested level; may change at any time |
| pwm_o | output | 1 | Registered pulse-width modulated output |
| period_start_o | output | 1 | One-clock strobe on the first clock of each period |

## Verification
The bench changes the level in the middle of a period and on the last clocks around the reload edge. A design that copied the input continuously would cut short or extend the current pulse. A design with the load point off by one clock would apply the change one period early or late. The extreme levels 0x00 and 0xFF are run to catch an inclusive compare, which would add a pulse at level 0 or hold the output high through a full period at 0xFF. Every clock of each period is compared against the expected prefix shape, so a pulse that rises twice in one period is caught, and so is a strobe that drifts from the period boundary.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

  // Outputs of the compare stage, kept together so they stay cycle-aligned.
  typedef struct packed {
    logic level;
    logic start;
  } pwm_out_t;

  function automatic int unsigned period_len(input int unsigned w);
    return 32'd1 << w;
  endfunction

endpackage

// File: rtl/pwm_ramp_counter.sv
module pwm_ramp_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] count_o,
  output logic             last_o
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic [WIDTH-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;  // natural wrap at TOP
    end
  end

  assign count_o = count_q;
  assign last_o  = (count_q == TOP);

endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] duty_i,
  output logic [WIDTH-1:0] duty_o
);

  logic [WIDTH-1:0] active_q;

  // The working level changes only on the wrap edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (load_i) begin
      active_q <= duty_i;
    end
  end

  assign duty_o = active_q;

endmodule

// File: rtl/pwm_compare_stage.sv
module pwm_compare_stage
  import pwm_dac_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] count_i,
  input  logic [WIDTH-1:0] duty_i,
  output pwm_out_t         out_o
);

  pwm_out_t out_q;
  pwm_out_t out_d;

  always_comb begin
    out_d.level = (count_i < duty_i);
    out_d.start = (count_i == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else begin
      out_q <= out_d;
    end
  end

  assign out_o = out_q;

endmodule

// File: rtl/pwm_dac_core.sv
module pwm_dac_core
  import pwm_dac_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] duty_in,
  output logic             pwm_o,
  output logic             period_start_o
);

  logic [WIDTH-1:0] count;
  logic             wrap;
  logic [WIDTH-1:0] duty_act;
  pwm_out_t         stage_out;

  pwm_ramp_counter #(.WIDTH(WIDTH)) u_ramp (
    .clk     (clk),
    .rst     (rst),
    .count_o (count),
    .last_o  (wrap)
  );

  pwm_duty_shadow #(.WIDTH(WIDTH)) u_shadow (
    .clk    (clk),
    .rst    (rst),
    .load_i (wrap),
    .duty_i (duty_in),
    .duty_o (duty_act)
  );

  pwm_compare_stage #(.WIDTH(WIDTH)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .count_i (count),
    .duty_i  (duty_act),
    .out_o   (stage_out)
  );

  assign pwm_o          = stage_out.level;
  assign period_start_o = stage_out.start;

endmodule

// File: rtl/pwm_dac_core_chk.sv
module pwm_dac_core_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic clk,
  input logic rst,
  input logic pwm_o,
  input logic period_start_o
);

  localparam int unsigned PERIOD = 1 << WIDTH;

  logic [WIDTH:0] gap_q;
  logic           seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (period_start_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!pwm_o && !period_start_o)); // R1

  AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (rst)
    (period_start_o && seen_q) |-> (gap_q == (WIDTH+1)'(PERIOD - 1))); // R2

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_o) |-> period_start_o); // R3

  AST_LAST_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
    (seen_q && gap_q == (WIDTH+1)'(PERIOD - 2)) |-> !pwm_o); // R5

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    period_start_o |=> !period_start_o); // R8

endmodule

bind pwm_dac_core pwm_dac_core_chk #(.WIDTH(WIDTH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .pwm_o          (pwm_o),
  .period_start_o (period_start_o)
);

// File: tb/test_pwm_dac_core.sv
module test_pwm_dac_core;

  localparam int W      = 8;
  localparam int PERIOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] duty_in = '0;
  logic         pwm_o;
  logic         period_start_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwm_dac_core #(.WIDTH(W)) i_pwm_dac_core (
    .clk            (clk),
    .rst            (rst),
    .duty_in        (duty_in),
    .pwm_o          (pwm_o),
    .period_start_o (period_start_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: got %0d cycles, expected fewer than 20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Measures one period starting at the next strobe. Optionally changes
  // duty_in at negedge index chg_idx (index 0 = strobe clock).
  task automatic measure(input int exp_d, input int chg_idx,
                         input logic [W-1:0] new_d, input string tag);
    int first_bad = -1;
    logic got_v = 1'b0;
    logic exp_v = 1'b0;
    int strobe_err = 0;
    while (period_start_o !== 1'b1) @(negedge clk);
    for (int i = 0; i < PERIOD; i++) begin
      if (pwm_o !== (i < exp_d) && first_bad < 0) begin
        first_bad = i;
        got_v = pwm_o;
        exp_v = (i < exp_d);
      end
      if (period_start_o !== (i == 0)) strobe_err++;
      if (i == chg_idx) duty_in = new_d;
      @(negedge clk);
    end
    total++;
    if (first_bad >= 0) begin
      bad++;
      $display("FAIL %s shape: idx %0d got %b expected %b (duty %0d)",
               tag, first_bad, got_v, exp_v, exp_d);
    end
    total++;
    if (strobe_err != 0) begin
      bad++;
      $display("FAIL R8 strobe inside period: got %0d extra, expected 0", strobe_err);
    end
    total++;
    if (period_start_o !== 1'b1) begin
      bad++;
      $display("FAIL R2 strobe after %0d clocks: got %b expected 1", PERIOD, period_start_o);
    end
  endtask

  task automatic t_reset;
    duty_in = 8'h80;
    rst = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      total++;
      if (pwm_o !== 1'b0 || period_start_o !== 1'b0) begin
        bad++;
        $display("FAIL R1 during reset: got pwm=%b strobe=%b expected 0 0",
                 pwm_o, period_start_o);
      end
    end
    rst = 1'b0;
    @(negedge clk);
    measure(0, -1, '0, "R1");       // level cleared by reset
    measure(8'h80, -1, '0, "R3");   // pending 0x80 now in use
  endtask

  task automatic t_mid_change;
    measure(8'h80, 100, 8'h40, "R6");
    measure(8'h40, 10, 8'hFA, "R6");
    measure(8'hFA, 0, 8'h00, "R3");
  endtask

  task automatic t_extremes;
    measure(0, 5, 8'hFF, "R4");
    measure(255, -1, '0, "R5");
  endtask

  task automatic t_boundary;
    measure(255, 254, 8'h01, "R5");   // last clock before reload edge
    measure(1, 255, 8'h33, "R7");     // one clock too late
    measure(1, -1, '0, "R7");         // deferred a full period
    measure(8'h33, -1, '0, "R7");
  endtask

  initial begin
    t_reset();
    t_mid_change();
    t_extremes();
    t_boundary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule